// File: doc/BRIEF.md
# Hex Word to ASCII Line Formatter

This block turns a binary word into a line of text for a character terminal. A word arrives on a valid/ready input. The block then sends a run of ASCII bytes on a valid/ready byte output. The run holds one uppercase hexadecimal character per nibble, starting with the most significant nibble, and ends with a carriage return and then a line feed. Leading zeros are always printed, so every line has the same width.

Each nibble is mapped to its character on its own, which closes the gap in the ASCII table between '9' and 'A'. The input side accepts one word at a time. It does not become ready again until the consumer has taken the line feed of the line in progress. A consumer that withholds ready can stall the block on any byte for as long as it likes, and the byte on offer does not change while it waits.

Top module: `hexword_line_fmt`

## Requirements
- R1: Every accepted word produces exactly four digit characters before its line end, leading zeros included; the word 0x0000 gives "0000" (0x30 four times) and then CR LF.
- R2: Digits leave in order from the nibble at bits 15:12 down to the nibble at bits 3:0.
- R3: A nibble value from 0 to 9 is sent as the byte 0x30 plus that value.
- R4: A nibble value from 10 to 15 is sent as an uppercase letter, 0x41 for ten up to 0x46 for fifteen.
- R5: After the fourth digit the block sends 0x0D (carriage return) and then 0x0A (line feed), and then no further byte until a new word is accepted.
- R6: in_ready falls in the cycle after a word is accepted and stays low until the line feed has been taken. It is high again in the following cycle. An in_valid while in_ready is low is ignored and adds no bytes to the output.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_byte keeps its value in the next cycle.
- R8: After a synchronous reset held high on the rising clock edge, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word is offered on in_word |
| in_ready | output | 1 | The block can take a word |
| in_word | input | 16 | Word to format |
| out_valid | output | 1 | out_byte holds a character |
| out_ready | input | 1 | The consumer takes out_byte |
| out_byte | output | 8 | ASCII character |

## Verification
The words sent are 0x0000, 0xFFFF, 0x1234, 0xABCD, 0x9A0F and 0xF00D. The all-zero word shows whether leading zeros are kept. The all-F word exercises only the letter branch. The mixed words place the 9-to-A boundary at different digit positions and show whether digit order is right. Each word is sent three ways: with the consumer always ready, with ready dropped on a repeating pattern, and with long stalls. These show whether bytes are held through stalls and whether a word offered while the block is busy leaks into the output.

// File: rtl/hexfmt_pkg.sv
package hexfmt_pkg;
    localparam int NIB_W = 4;
    localparam logic [7:0] CH_CR   = 8'h0D;
    localparam logic [7:0] CH_LF   = 8'h0A;
    localparam logic [7:0] CH_ZERO = 8'h30;
    localparam logic [7:0] CH_A    = 8'h41;

    typedef enum logic [1:0] {
        SLOT_DIGIT = 2'd0,
        SLOT_CR    = 2'd1,
        SLOT_LF    = 2'd2
    } slot_kind_e;

    function automatic logic [7:0] nib_to_char(input logic [NIB_W-1:0] n);
        logic [7:0] wide;
        wide = {{(8-NIB_W){1'b0}}, n};
        if (wide < 8'd10)
            return CH_ZERO + wide;
        else
            return CH_A + (wide - 8'd10);
    endfunction
endpackage

// File: rtl/hexfmt_digit_lut.sv
module hexfmt_digit_lut
    import hexfmt_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output logic [7:0]       ch
);
    always_comb begin
        ch = nib_to_char(nib);
    end

    // R3, R4: the character lands in the digit run or the letter run
    always_comb begin
        p_char_class_r4: assert ((ch >= 8'h30 && ch <= 8'h39) || (ch >= 8'h41 && ch <= 8'h46))
            else $error("character outside hex alphabet");
    end
endmodule

// File: rtl/hexfmt_seq.sv
module hexfmt_seq
    import hexfmt_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int SLOTS = DIGITS + 2,
    localparam int POS_W = $clog2(SLOTS),
    localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             load,
    output logic             out_valid,
    input  logic             out_ready,
    output slot_kind_e       kind,
    output logic [IDX_W-1:0] digit_idx
);
    typedef struct packed {
        logic             busy;
        logic [POS_W-1:0] pos;
    } seq_state_t;

    localparam logic [POS_W-1:0] POS_CR   = POS_W'(DIGITS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(DIGITS + 1);

    seq_state_t st_q, st_d;
    logic       fire;

    assign in_ready  = !st_q.busy;
    assign out_valid = st_q.busy;
    assign load      = in_valid && !st_q.busy;
    assign fire      = st_q.busy && out_ready;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.pos  = '0;
        end else if (fire) begin
            if (st_q.pos == POS_LAST) begin
                st_d.busy = 1'b0;
                st_d.pos  = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{busy: 1'b0, pos: '0};
        else     st_q <= st_d;
    end

    always_comb begin
        if (st_q.pos < POS_CR)       kind = SLOT_DIGIT;
        else if (st_q.pos == POS_CR) kind = SLOT_CR;
        else                         kind = SLOT_LF;
        digit_idx = IDX_W'(DIGITS - 1 - int'(st_q.pos));
    end

    // R6: an accepted word makes the block busy at once
    p_accept_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && !in_ready));

    // R5: position never runs past the line feed slot
    p_pos_bound_r5: assert property (@(posedge clk) disable iff (rst)
        st_q.pos <= POS_LAST);
endmodule

// File: rtl/hexword_line_fmt.sv
module hexword_line_fmt
    import hexfmt_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int DIGITS = WORD_W / NIB_W,
    localparam int IDX_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte
);
    logic [WORD_W-1:0] word_q;
    logic              load;
    slot_kind_e        kind;
    logic [IDX_W-1:0]  digit_idx;
    logic [7:0]        chars [DIGITS];

    hexfmt_seq #(.DIGITS(DIGITS)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .load      (load),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .kind      (kind),
        .digit_idx (digit_idx)
    );

    always_ff @(posedge clk) begin
        if (rst)       word_q <= '0;
        else if (load) word_q <= in_word;
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_lut
        hexfmt_digit_lut i_lut (
            .nib (word_q[g*NIB_W +: NIB_W]),
            .ch  (chars[g])
        );
    end

    always_comb begin
        case (kind)
            SLOT_DIGIT: out_byte = chars[digit_idx];
            SLOT_CR:    out_byte = CH_CR;
            default:    out_byte = CH_LF;
        endcase
    end

    // R7: a stalled byte is held
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    // R6: taking the line feed frees the input side
    p_lf_release_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_byte == CH_LF) |=> (in_ready && !out_valid));

    // R5: the byte after a taken CR is LF
    p_cr_then_lf_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_byte == CH_CR) |=> (out_valid && out_byte == CH_LF));
endmodule

// File: tb/test_hexword_line_fmt.sv
module test_hexword_line_fmt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_byte;

    int n_checks = 0;
    int n_fail   = 0;
    int rdy_mode = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic [7:0] exp_byte [$];
    string      exp_req  [$];

    always #10 clk = ~clk;

    hexword_line_fmt i_hexword_line_fmt (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_byte(out_byte)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_char(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        return 8'h41 + ({4'h0, n} - 8'd10);
    endfunction

    task automatic send(input logic [15:0] w, input bit poke_busy);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        for (int i = 3; i >= 0; i--) begin
            logic [3:0] n;
            n = w[i*4 +: 4];
            exp_byte.push_back(ref_char(n));
            if (w == 16'h0000)  exp_req.push_back("R1");
            else if (i == 3)    exp_req.push_back("R2");
            else if (n < 4'd10) exp_req.push_back("R3");
            else                exp_req.push_back("R4");
        end
        exp_byte.push_back(8'h0D); exp_req.push_back("R5");
        exp_byte.push_back(8'h0A); exp_req.push_back("R5");
        @(negedge clk);
        if (poke_busy) begin
            in_word = ~w;
            @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // monitor and scoreboard
    initial begin
        bit         held = 1'b0;
        logic [7:0] held_b = '0;
        bit         lf_taken = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                if (held) begin
                    check("R7 valid held", {15'h0, out_valid}, 16'h1);
                    check("R7 byte held", {8'h0, out_byte}, {8'h0, held_b});
                end
                if (lf_taken) check("R6 ready after LF", {15'h0, in_ready}, 16'h1);
                lf_taken = 1'b0;
                case (rdy_mode)
                    0: out_ready = 1'b1;
                    1: out_ready = (cyc % 3) != 0;
                    default: out_ready = (cyc % 8) == 0;
                endcase
                if (out_valid) check("R6 busy blocks input", {15'h0, in_ready}, 16'h0);
                held = out_valid && !out_ready;
                held_b = out_byte;
                if (out_valid && out_ready) begin
                    if (exp_byte.size() == 0) begin
                        n_checks++; n_fail++;
                        $display("FAIL R6 extra byte actual=%h expected=none", out_byte);
                    end else begin
                        logic [7:0] e;
                        string r;
                        e = exp_byte.pop_front();
                        r = exp_req.pop_front();
                        check(r, {8'h0, out_byte}, {8'h0, e});
                        if (e == 8'h0A) lf_taken = 1'b1;
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] words [6];
        words = '{16'h0000, 16'hFFFF, 16'h1234, 16'hABCD, 16'h9A0F, 16'hF00D};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R8 out_valid after reset", {15'h0, out_valid}, 16'h0);
        check("R8 in_ready after reset", {15'h0, in_ready}, 16'h1);
        for (int m = 0; m < 3; m++) begin
            rdy_mode = m;
            for (int k = 0; k < 6; k++) send(words[k], (k % 2) == 1);
        end
        while (exp_byte.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        check("R5 idle after last LF", {15'h0, out_valid}, 16'h0);
        check("R6 ready when idle", {15'h0, in_ready}, 16'h1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule